// File: doc/BRIEF.md
# Multimode Timer with Capture and Reload

This block holds one 16-bit core timer and two 16-bit auxiliary timers. Each timer counts in one of four ways: prescaled clock ticks, prescaled ticks gated by a high level on its input pin, the same gated by a low level, or selected edges on its input pin. A software bit sets the count direction, and an enable bit hands the direction to an external pin instead. All external pins pass through a two-flop synchronizer before they are used.

Each auxiliary timer can instead act as a capture register or a reload register for the core timer. In either role it stops counting. A capture register takes a copy of the core value on an edge of its own input pin. A reload register loads the core timer from its own value. The trigger is an edge on its pin or a chosen transition of the core's toggle latch. The latch inverts on every core wrap. When one reload register is tied to the latch's rising transition and the other to its falling transition, the latch output becomes a continuous PWM waveform. No software action is needed once it starts.

Software uses a single write port. Value registers sit at addresses 0 (core), 1 and 2 (auxiliaries). Control words sit at 3, 4 and 5. Address 6 clears interrupt flags.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset all three timer values, all interrupt flags and the toggle output are 0.
- R2: Control word bits: [1:0] mode (0 timer, 1 gate active high, 2 gate active low, 3 edge counter), [2] run, [3] count down, [4] direction from pin, [7:5] prescale select, [9:8] edge select (bit 8 rising, bit 9 falling), [11:10] auxiliary role (0 timer, 1 capture, 2 reload), [12] reload on latch rise, [13] reload on latch fall, [14] toggle output enable. In timer mode a running timer advances once every 8<<select clocks, and the first step comes 8<<select clocks after the write that sets run.
- R3: In a gated mode the timer advances on prescaler ticks only while its synchronized input pin is at the active level.
- R4: In edge counter mode the timer advances once per selected edge of its input pin. The count shows within four clocks of the pin change.
- R5: Without the pin enable, bit 3 picks the direction (1 = down). With the pin enable set, a high direction pin counts down and a low one counts up.
- R6: A step from 0xFFFF up to 0x0000, or from 0x0000 down to 0xFFFF, sets that timer's flag (flag bit = timer index, 0 = core). On a core wrap the toggle latch also inverts. The toggle output shows the latch while bit 14 is set.
- R7: An auxiliary timer in capture role holds its value. On a selected edge of its pin while run is set, it copies the core value and sets its own flag.
- R8: An auxiliary timer in reload role holds its value. It loads the core on a selected pin edge or a selected latch transition while run is set. On a latch-triggered reload the core takes the reload value in place of the wrapped value.
- R9: With auxiliary 0 reloading on the latch rise and auxiliary 1 on the latch fall, the output stays high for (0x10000 − aux0) and low for (0x10000 − aux1) core steps, repeating.
- R10: Writing to address 6 clears each flag whose data bit is 1.
- R11: A software write to the core value wins over a reload, and a reload from auxiliary 0 wins over one from auxiliary 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| tin | input | 3 | Per-timer input pin (gate, count, capture or reload trigger) |
| tdir | input | 3 | Per-timer external direction pin |
| tout | output | 1 | Toggle latch output |
| core_val | output | 16 | Core timer value |
| aux0_val | output | 16 | Auxiliary timer 0 value |
| aux1_val | output | 16 | Auxiliary timer 1 value |
| irq | output | 3 | Wrap/capture interrupt flags, bit = timer index |

## Verification
A wrong prescaler phase shows up at the first timed check as a value that is off by one. It is visible within one prescale period of the start write. A latch that holds the wrong phase swaps the high and low widths of the PWM waveform, so the bench measures both widths directly. A reload or capture that picks the wrong source, or fires when it should not, corrupts the core or auxiliary value in the same cycle. The next sample of that port exposes it.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CTRL_W = 16;
    localparam int ADDR_W = 3;
    localparam int NT     = 3;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd6;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_GATE_HI = 2'd1,
        MODE_GATE_LO = 2'd2,
        MODE_COUNT   = 2'd3
    } crt_mode_e;

    typedef enum logic [1:0] {
        FN_TIMER   = 2'd0,
        FN_CAPTURE = 2'd1,
        FN_RELOAD  = 2'd2,
        FN_SPARE   = 2'd3
    } crt_fn_e;

    typedef struct packed {
        logic       rsvd;
        logic       out_en;
        logic       rl_on_fall;
        logic       rl_on_rise;
        crt_fn_e    fn;
        logic [1:0] edge_sel;
        logic [2:0] psel;
        logic       dir_pin_en;
        logic       down;
        logic       run;
        crt_mode_e  mode;
    } crt_ctrl_t;

    function automatic logic edge_pick(logic [1:0] sel, logic rise, logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction
endpackage

// File: rtl/crt_sync.sv
module crt_sync #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;

    // R4: a detected edge is a single-cycle pulse
    p_rise_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> !rise[0]);
endmodule

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
    parameter int BASE_LOG = 3,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask     = ~({CNT_W{1'b1}} << (BASE_LOG + int'(sel)));
        tick     = run && ((st_q.cnt & mask) == mask);
        st_d     = st_q;
        st_d.cnt = run ? st_q.cnt + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the smallest division is 8, so ticks never come back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         down,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] val,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] val;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = en && (down ? (st_q.val == '0) : (&st_q.val));
        if (load)    st_d.val = load_val;
        else if (en) st_d.val = down ? st_q.val - 1'b1 : st_q.val + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;

    // R2: an enabled up step adds exactly one
    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !down) |=> (val == W'($past(val) + 1'b1)));
    // R5: an enabled down step subtracts exactly one
    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && down) |=> (val == W'($past(val) - 1'b1)));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int W        = 16,
    parameter int BASE_LOG = 3,
    parameter int SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [NT-1:0]     tin,
    input  logic [NT-1:0]     tdir,
    output logic              tout,
    output logic [W-1:0]      core_val,
    output logic [W-1:0]      aux0_val,
    output logic [W-1:0]      aux1_val,
    output logic [NT-1:0]     irq
);
    typedef struct packed {
        crt_ctrl_t [NT-1:0] ctrl;
        logic               latch;
        logic [NT-1:0]      irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [2*NT-1:0]       s_lvl, s_rise, s_fall;
    logic [NT-1:0]         tick, en, down, wrap, pin_ev, load;
    logic [NT-1:0]         wr_val_hit, wr_ctl_hit;
    logic [NT-1:0]         cap, rl;
    logic [NT-1:0][W-1:0]  cnt_val, load_val;
    logic                  lrise, lfall;

    crt_sync #(.N(2*NT)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .pin ({tdir, tin}),
        .lvl (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        crt_prescaler #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_psc (
            .clk (clk),
            .rst_n (rst_n),
            .run (st_q.ctrl[g].run),
            .sel (st_q.ctrl[g].psel),
            .tick (tick[g])
        );
        crt_counter #(.W(W)) u_cnt (
            .clk (clk),
            .rst_n (rst_n),
            .en (en[g]),
            .down (down[g]),
            .load (load[g]),
            .load_val (load_val[g]),
            .val (cnt_val[g]),
            .wrap (wrap[g])
        );
    end

    // Per-timer decode: count enable, direction, pin events, write hits
    always_comb begin
        crt_ctrl_t cfg;
        logic      counting, adv;
        for (int i = 0; i < NT; i++) begin
            cfg        = st_q.ctrl[i];
            counting   = (i == 0) || (cfg.fn == FN_TIMER) || (cfg.fn == FN_SPARE);
            pin_ev[i]  = edge_pick(cfg.edge_sel, s_rise[i], s_fall[i]);
            case (cfg.mode)
                MODE_TIMER:   adv = tick[i];
                MODE_GATE_HI: adv = tick[i] & s_lvl[i];
                MODE_GATE_LO: adv = tick[i] & ~s_lvl[i];
                default:      adv = pin_ev[i];
            endcase
            en[i]         = counting && cfg.run && adv;
            down[i]       = cfg.dir_pin_en ? s_lvl[NT+i] : cfg.down;
            wr_val_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
            wr_ctl_hit[i] = wr_en && (wr_addr == ADDR_W'(NT + i));
        end
    end

    // Next state, capture and reload
    always_comb begin
        crt_ctrl_t cfg;
        logic      trig_pin;
        st_d  = st_q;
        lrise = wrap[0] & ~st_q.latch;
        lfall = wrap[0] & st_q.latch;
        st_d.latch = st_q.latch ^ wrap[0];
        cap = '0;
        rl  = '0;
        for (int k = 1; k < NT; k++) begin
            cfg      = st_q.ctrl[k];
            trig_pin = cfg.run & pin_ev[k];
            cap[k]   = (cfg.fn == FN_CAPTURE) && trig_pin;
            rl[k]    = (cfg.fn == FN_RELOAD) &&
                       (trig_pin || (cfg.run && cfg.rl_on_rise && lrise) ||
                                    (cfg.run && cfg.rl_on_fall && lfall));
        end

        // core load: software, then aux0 reload, then aux1 reload
        load[0]     = 1'b1;
        load_val[0] = cnt_val[0];
        if (wr_val_hit[0])  load_val[0] = wr_data;
        else if (rl[1])     load_val[0] = cnt_val[1];
        else if (rl[2])     load_val[0] = cnt_val[2];
        else                load[0]     = 1'b0;

        for (int k = 1; k < NT; k++) begin
            load[k]     = wr_val_hit[k] || cap[k];
            load_val[k] = wr_val_hit[k] ? wr_data : cnt_val[0];
        end

        for (int i = 0; i < NT; i++) begin
            st_d.irq[i] = (st_q.irq[i] & ~(wr_en && (wr_addr == ADDR_FLAGS) && wr_data[i]))
                          | wrap[i] | cap[i];
            if (wr_ctl_hit[i]) st_d.ctrl[i] = crt_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tout     = st_q.latch & st_q.ctrl[0].out_en;
    assign core_val = cnt_val[0];
    assign aux0_val = cnt_val[1];
    assign aux1_val = cnt_val[2];
    assign irq      = st_q.irq;

    // R6: every core wrap inverts the latch
    p_latch_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[0] |=> (st_q.latch != $past(st_q.latch)));
    // R6: a core wrap raises the core flag
    p_irq_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[0] |=> irq[0]);
    // R7: a capture register holds when neither written nor triggered
    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ctrl[1].fn == FN_CAPTURE) && !wr_val_hit[1] && !cap[1]) |=> $stable(aux0_val));
    // R8: a reload from aux0 moves its value into the core
    p_reload_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rl[1] && !wr_val_hit[0]) |=> (core_val == $past(aux0_val)));
endmodule

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  tin = '0;
    logic [2:0]  tdir = '0;
    logic        tout;
    logic [15:0] core_val, aux0_val, aux1_val;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .tin (tin), .tdir (tdir), .tout (tout),
        .core_val (core_val), .aux0_val (aux0_val), .aux1_val (aux1_val), .irq (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic stop_all();
        wr(3, 16'h0000); wr(4, 16'h0000); wr(5, 16'h0000);
    endtask

    task automatic pulse(int idx);
        @(negedge clk); tin[idx] = 1'b1;
        repeat (4) @(negedge clk); tin[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 core", core_val, 0);
        check("R1 aux0", aux0_val, 0);
        check("R1 aux1", aux1_val, 0);
        check("R1 irq", irq, 0);
        check("R1 tout", tout, 0);
    endtask

    task automatic t_timer();
        wr(0, 16'h0000);
        wr(3, 16'h0004);
        wait_edges(8 * 5);
        check("R2 div8", core_val, 5);
        wr(3, 16'h0000); wr(0, 16'h0000);
        wr(3, 16'h0024);
        wait_edges(16 * 3);
        check("R2 div16", core_val, 3);
        wr(3, 16'h0000);
        wr(2, 16'h0000);
        wr(5, 16'h0004);
        wait_edges(8 * 2);
        check("R2 aux timer", aux1_val, 2);
        wr(5, 16'h0000);
    endtask

    task automatic t_dir();
        wr(0, 16'd5);
        wr(3, 16'h000C);
        wait_edges(8 * 3);
        check("R5 down bit", core_val, 2);
        wr(3, 16'h0000); wr(0, 16'd10);
        tdir[0] = 1'b1; wait_edges(4);
        wr(3, 16'h0014);
        wait_edges(8 * 2);
        check("R5 pin down", core_val, 8);
        wr(3, 16'h0000); wr(0, 16'd10);
        tdir[0] = 1'b0; wait_edges(4);
        wr(3, 16'h0014);
        wait_edges(8 * 2);
        check("R5 pin up", core_val, 12);
        wr(3, 16'h0000);
    endtask

    task automatic t_wrap();
        wr(6, 16'h0007);
        wr(0, 16'hFFFE);
        wr(3, 16'h4004);
        wait_edges(8 * 2);
        check("R6 up wrap value", core_val, 0);
        check("R6 up wrap irq", irq[0], 1);
        check("R6 latch high", tout, 1);
        wr(3, 16'h4000);
        wr(6, 16'h0001);
        check("R10 flag clear", irq, 0);
        wr(3, 16'h400C);
        wait_edges(8 * 1);
        check("R6 down wrap value", core_val, 16'hFFFF);
        check("R6 down wrap irq", irq[0], 1);
        check("R6 latch low", tout, 0);
        wr(3, 16'h0000);
        wr(6, 16'h0007);
    endtask

    task automatic t_gated();
        wr(0, 16'h0000);
        tin[0] = 1'b0; wait_edges(4);
        wr(3, 16'h0005);
        wait_edges(8 * 4);
        check("R3 gate closed", core_val, 0);
        wr(3, 16'h0000); wr(0, 16'h0000);
        tin[0] = 1'b1; wait_edges(4);
        wr(3, 16'h0005);
        wait_edges(8 * 3);
        check("R3 gate open", core_val, 3);
        wr(3, 16'h0000); wr(0, 16'h0000);
        wr(3, 16'h0006);
        wait_edges(8 * 3);
        check("R3 active low held", core_val, 0);
        wr(3, 16'h0000);
        tin[0] = 1'b0; wait_edges(4);
    endtask

    task automatic t_counter();
        wr(0, 16'h0000);
        wr(3, 16'h0107);
        for (int i = 0; i < 3; i++) pulse(0);
        wait_edges(4);
        check("R4 rising edges", core_val, 3);
        wr(3, 16'h0000); wr(0, 16'h0000);
        wr(3, 16'h0307);
        for (int i = 0; i < 2; i++) pulse(0);
        wait_edges(4);
        check("R4 both edges", core_val, 4);
        wr(3, 16'h0000);
    endtask

    task automatic t_capture();
        wr(0, 16'h1234);
        wr(1, 16'h0007);
        wr(4, 16'h0504);
        wait_edges(40);
        check("R7 capture holds", aux0_val, 16'h0007);
        pulse(1);
        check("R7 captured value", aux0_val, 16'h1234);
        check("R7 capture flag", irq[1], 1);
        wr(6, 16'h0007);
        check("R10 all cleared", irq, 0);
        wr(4, 16'h0000);
    endtask

    task automatic t_reload();
        wr(2, 16'h0ABC);
        wr(5, 16'h0904);
        pulse(2);
        check("R8 pin reload", core_val, 16'h0ABC);
        wr(5, 16'h0000);
        // latch is low here; next up wrap raises it
        wr(1, 16'h8000);
        wr(4, 16'h1804);
        wr(0, 16'hFFFE);
        wr(3, 16'h4004);
        wait_edges(8 * 2);
        check("R8 latch reload", core_val, 16'h8000);
        check("R8 latch rose", tout, 1);
        wr(3, 16'h0000);
    endtask

    task automatic t_pwm();
        int hi = 0;
        int lo = 0;
        int guard = 0;
        wr(1, 16'hFFFE);
        wr(2, 16'hFFFD);
        wr(4, 16'h1804);
        wr(5, 16'h2804);
        wr(0, 16'hFFFF);
        wr(3, 16'h4004);
        while (tout !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
        while (tout !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
        while (tout === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
        while (tout === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
        check("R9 high width", hi, 16);
        check("R9 low width", lo, 24);
        stop_all();
    endtask

    task automatic t_prio();
        wr(1, 16'h1111);
        wr(2, 16'h2222);
        wr(4, 16'h0904);
        wr(5, 16'h0904);
        @(negedge clk); tin[1] = 1'b1; tin[2] = 1'b1;
        repeat (4) @(negedge clk); tin[1] = 1'b0; tin[2] = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 aux0 wins", core_val, 16'h1111);
        wr(4, 16'h0000);
        pulse(2);
        check("R11 aux1 alone", core_val, 16'h2222);
        stop_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timer();
        t_dir();
        t_wrap();
        t_gated();
        t_counter();
        t_capture();
        t_reload();
        t_pwm();
        t_prio();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule